// File: doc/BRIEF.md
# Frame Buffer Address Generator

This block turns a stream of 24-bit RGB pixels and its line and frame strobes into word writes for an external frame store of 128-bit words. It also produces the read address that an output pipeline walks through. Each buffer has a fixed size and every line sits at a fixed stride from the buffer base, so the position of a pixel depends only on its line and column and never on the size of the incoming frame. Five pixels share each memory word. When a frame is finished, its width and height are written into the last two words of its buffer so that software can take a snapshot without knowing the video timing.

A mode input picks one of two buffering schemes. With a single buffer, writer and reader share buffer 0. With three buffers, the writer and the reader rotate through the buffers so that the reader never sees a frame that is still being written. The memory controller, burst arbitration and scaling sit outside this block. The source must keep the write line strobe low for the two cycles after a write frame strobe.

Top module: `fbuf_addr_gen`

## Requirements
- R1: While reset is held and just after it is released, `wr_en` is low. The internal write buffer is 0 and the read and last-completed buffers are 2. So in triple mode `rd_buf` reads 2 and `rd_addr` equals 2*BUF_WORDS, and in single mode both read as 0.
- R2: Accepted pixels fill a word in arrival order. Pixel k of a word (k = 0..4) sits in bits [24k+23:24k] and bits [127:120] are zero. The word is written, with `wr_en` high, in the cycle after the fifth pixel is accepted.
- R3: A pixel word goes to word address buffer*BUF_WORDS + line*LINE_WORDS + w, where line counts from 0 at the frame strobe and w counts the words already written in that line.
- R4: A write line strobe or a write frame strobe that finds 1 to 4 pixels pending writes them in the next cycle as a zero-padded word at the current word position. If no pixels are pending, nothing is written.
- R5: Pixels past MAX_W in a line are dropped. The line index stops at MAX_H, and pixels on lines at or past MAX_H are dropped. No write reaches a word between MAX_H*LINE_WORDS and BUF_WORDS-3 of a buffer.
- R6: A write frame strobe that ends a frame writes the frame width at word BUF_WORDS-2 of that frame's buffer in the second cycle after the strobe, and the height at word BUF_WORDS-1 in the third cycle. The width is the largest accepted pixel count of any line. The height is the line index plus one, capped at MAX_H.
- R7: In triple mode, a frame end moves the writer to the buffer that is neither the one being read nor the frame just completed. If a read frame request arrives in the same cycle, the writer instead takes the buffer the reader is leaving.
- R8: A read frame request makes `rd_buf` the most recently completed buffer, which is never the buffer being written.
- R9: With `triple_en` low, `rd_buf` is 0 and all writes and reads fall in buffer 0.
- R10: A read frame request sets the read line and word to 0. A read line request advances the line, saturating at MAX_H-1, and sets the word to 0. A word advance steps the word, saturating at LINE_WORDS-1. `rd_addr` = rd_buf*BUF_WORDS + line*LINE_WORDS + word.
- R11: A pixel is ignored if it arrives in the same cycle as a write strobe or before the first write frame strobe after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| triple_en | input | 1 | 1 selects three rotating buffers, 0 selects one shared buffer |
| wr_pix_valid | input | 1 | Incoming pixel is valid |
| wr_pix | input | 24 | Incoming RGB pixel |
| wr_line_start | input | 1 | Next write line begins |
| wr_frame_start | input | 1 | Next write frame begins |
| rd_frame_start | input | 1 | Reader starts a new frame |
| rd_line_start | input | 1 | Reader moves to the next line |
| rd_word_adv | input | 1 | Reader steps to the next word of the line |
| wr_en | output | 1 | Write strobe for the memory word |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | 128 | Word to write |
| rd_addr | output | ADDR_W | Word address for the reader |
| rd_buf | output | 2 | Buffer the reader is using |

## Verification
A pixel word shows up on the write port one cycle after the edge that takes its fifth pixel, and a partial flush one cycle after the strobe edge. The width word follows two cycles after a frame-ending strobe and the height word three cycles after it. The read address and `rd_buf` take their new value just after the edge that samples the request. The bench keeps a behavioural model that advances at every rising edge and compares at the following falling edge, so each expected value is matched against the cycle in which the registered output becomes valid.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int PIX_W        = 24;
  localparam int WORD_W       = 128;
  localparam int PIX_PER_WORD = WORD_W / PIX_W;

  typedef logic [1:0] buf_idx_t;

  // Word address of word 'word' on line 'line' in buffer 'bidx'.
  function automatic int unsigned fb_addr(input int unsigned bidx,
                                          input int unsigned line,
                                          input int unsigned word,
                                          input int unsigned buf_words,
                                          input int unsigned line_words);
    return bidx * buf_words + line * line_words + word;
  endfunction

  // Third buffer of {0,1,2}, given two distinct others.
  function automatic buf_idx_t spare_buf(input buf_idx_t a, input buf_idx_t b);
    return buf_idx_t'(2'd3 - a - b);
  endfunction
endpackage

// File: rtl/fbuf_rotator.sv
module fbuf_rotator
  import fbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_done,
  input  logic     rd_frame_start,
  output buf_idx_t wr_idx,
  output buf_idx_t rd_idx,
  output buf_idx_t done_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx   <= 2'd0;
      rd_idx   <= 2'd2;
      done_idx <= 2'd2;
    end else if (frame_done) begin
      done_idx <= wr_idx;
      if (rd_frame_start) begin
        rd_idx <= wr_idx;
        wr_idx <= rd_idx;
      end else begin
        wr_idx <= spare_buf(rd_idx, wr_idx);
      end
    end else if (rd_frame_start) begin
      rd_idx <= done_idx;
    end
  end
endmodule

// File: rtl/fbuf_packer.sv
module fbuf_packer
  import fbuf_pkg::*;
#(
  parameter int MAX_W      = 1920,
  parameter int MAX_H      = 1080,
  parameter int LINE_WORDS = 384,
  parameter int BUF_WORDS  = 524288,
  parameter int ADDR_W     = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_valid,
  input  logic [PIX_W-1:0]    pix,
  input  logic                line_start,
  input  logic                frame_start,
  input  buf_idx_t            base_idx,
  output logic                frame_done,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data
);
  localparam int ACC_W = PIX_PER_WORD * PIX_W;
  localparam int PAD_W = WORD_W - ACC_W;
  localparam int CW    = $clog2(MAX_W + 1);
  localparam int LNW   = $clog2(MAX_H + 1);
  localparam int WIW   = $clog2(LINE_WORDS + 1);
  localparam int SLW   = $clog2(PIX_PER_WORD);

  logic             act;
  logic [LNW-1:0]   line;
  logic [CW-1:0]    col, wmax;
  logic [WIW-1:0]   widx;
  logic [SLW-1:0]   slot;
  logic [ACC_W-1:0] acc, next_acc;
  logic [1:0]       meta_ph;
  logic [CW-1:0]    meta_w;
  logic [LNW-1:0]   meta_h;
  buf_idx_t         meta_idx;

  logic             line_ok, col_ok, pix_take, has_part;
  logic [CW-1:0]    cur_w;
  logic [LNW-1:0]   cur_h;
  logic [ADDR_W-1:0] cur_addr;

  always_comb begin
    frame_done = frame_start & act;
    line_ok    = line < LNW'(MAX_H);
    col_ok     = col < CW'(MAX_W);
    pix_take   = pix_valid & ~line_start & ~frame_start & act & line_ok & col_ok;
    has_part   = slot != '0;
    cur_w      = (col > wmax) ? col : wmax;
    cur_h      = line_ok ? line + LNW'(1) : LNW'(MAX_H);
    cur_addr   = ADDR_W'(fb_addr(32'(base_idx), 32'(line), 32'(widx),
                                 BUF_WORDS, LINE_WORDS));
    next_acc   = acc;
    next_acc[32'(slot)*PIX_W +: PIX_W] = pix;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; line <= '0; col <= '0; wmax <= '0; widx <= '0;
      slot <= '0; acc <= '0; meta_ph <= 2'd0; meta_w <= '0; meta_h <= '0;
      meta_idx <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      // metadata words trail a frame end by one and two cycles
      if (meta_ph == 2'd1) begin
        wr_en   <= 1'b1;
        wr_addr <= ADDR_W'(fb_addr(32'(meta_idx), 0, BUF_WORDS - 2,
                                   BUF_WORDS, LINE_WORDS));
        wr_data <= {{(WORD_W-CW){1'b0}}, meta_w};
        meta_ph <= 2'd2;
      end else if (meta_ph == 2'd2) begin
        wr_en   <= 1'b1;
        wr_addr <= ADDR_W'(fb_addr(32'(meta_idx), 0, BUF_WORDS - 1,
                                   BUF_WORDS, LINE_WORDS));
        wr_data <= {{(WORD_W-LNW){1'b0}}, meta_h};
        meta_ph <= 2'd0;
      end

      if (frame_start) begin
        if (act) begin
          if (has_part) begin
            wr_en   <= 1'b1;
            wr_addr <= cur_addr;
            wr_data <= {{PAD_W{1'b0}}, acc};
          end
          meta_ph  <= 2'd1;
          meta_w   <= cur_w;
          meta_h   <= cur_h;
          meta_idx <= base_idx;
        end
        act <= 1'b1; line <= '0; col <= '0; wmax <= '0;
        widx <= '0; slot <= '0; acc <= '0;
      end else if (line_start) begin
        if (act) begin
          if (has_part) begin
            wr_en   <= 1'b1;
            wr_addr <= cur_addr;
            wr_data <= {{PAD_W{1'b0}}, acc};
          end
          wmax <= cur_w;
          if (line_ok) line <= line + LNW'(1);
          col <= '0; widx <= '0; slot <= '0; acc <= '0;
        end
      end else if (pix_take) begin
        col <= col + CW'(1);
        if (slot == SLW'(PIX_PER_WORD - 1)) begin
          wr_en   <= 1'b1;
          wr_addr <= cur_addr;
          wr_data <= {{PAD_W{1'b0}}, next_acc};
          widx    <= widx + WIW'(1);
          slot    <= '0;
          acc     <= '0;
        end else begin
          acc  <= next_acc;
          slot <= slot + SLW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fbuf_reader.sv
module fbuf_reader
  import fbuf_pkg::*;
#(
  parameter int MAX_H      = 1080,
  parameter int LINE_WORDS = 384,
  parameter int BUF_WORDS  = 524288,
  parameter int ADDR_W     = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              word_adv,
  input  buf_idx_t          rd_idx,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int RLW = $clog2(MAX_H + 1);
  localparam int RWW = $clog2(LINE_WORDS + 1);

  logic [RLW-1:0] rline;
  logic [RWW-1:0] rword;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rline <= '0;
      rword <= '0;
    end else if (frame_start) begin
      rline <= '0;
      rword <= '0;
    end else if (line_start) begin
      if (rline < RLW'(MAX_H - 1)) rline <= rline + RLW'(1);
      rword <= '0;
    end else if (word_adv) begin
      if (rword < RWW'(LINE_WORDS - 1)) rword <= rword + RWW'(1);
    end
  end

  assign rd_addr = ADDR_W'(fb_addr(32'(rd_idx), 32'(rline), 32'(rword),
                                   BUF_WORDS, LINE_WORDS));
endmodule

// File: rtl/fbuf_addr_gen.sv
module fbuf_addr_gen
  import fbuf_pkg::*;
#(
  parameter int MAX_W      = 1920,
  parameter int MAX_H      = 1080,
  parameter int LINE_WORDS = 384,
  parameter int BUF_WORDS  = 524288,
  parameter int ADDR_W     = $clog2(3 * BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              triple_en,
  input  logic              wr_pix_valid,
  input  logic [23:0]       wr_pix,
  input  logic              wr_line_start,
  input  logic              wr_frame_start,
  input  logic              rd_frame_start,
  input  logic              rd_line_start,
  input  logic              rd_word_adv,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [127:0]      wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_buf
);
  buf_idx_t wr_idx, rd_idx, done_idx;
  buf_idx_t eff_wr_idx;
  logic     frame_done;

  assign eff_wr_idx = triple_en ? wr_idx : 2'd0;
  assign rd_buf     = triple_en ? rd_idx : 2'd0;

  fbuf_rotator u_rot (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .rd_frame_start(rd_frame_start),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .done_idx(done_idx)
  );

  fbuf_packer #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .LINE_WORDS(LINE_WORDS),
    .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .pix_valid(wr_pix_valid), .pix(wr_pix),
    .line_start(wr_line_start), .frame_start(wr_frame_start),
    .base_idx(eff_wr_idx), .frame_done(frame_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fbuf_reader #(
    .MAX_H(MAX_H), .LINE_WORDS(LINE_WORDS),
    .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .frame_start(rd_frame_start),
    .line_start(rd_line_start), .word_adv(rd_word_adv),
    .rd_idx(rd_buf), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/fbuf_addr_gen_chk.sv
module fbuf_addr_gen_chk #(
  parameter int MAX_H      = 1080,
  parameter int LINE_WORDS = 384,
  parameter int BUF_WORDS  = 524288,
  parameter int ADDR_W     = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              triple_en,
  input logic              rd_frame_start,
  input logic              frame_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [127:0]      wr_data,
  input logic [1:0]        wr_idx,
  input logic [1:0]        rd_idx,
  input logic [1:0]        done_idx
);
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[127:120] == 8'd0);

  a_r5_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((int'(wr_addr) % BUF_WORDS) < MAX_H * LINE_WORDS) ||
              ((int'(wr_addr) % BUF_WORDS) >= BUF_WORDS - 2));

  a_r6_width_word: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ##1 (wr_en && (int'(wr_addr) % BUF_WORDS) == BUF_WORDS - 2));

  a_r7_writer_spare: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !rd_frame_start |=>
      (wr_idx != $past(rd_idx)) && (wr_idx != $past(wr_idx)));

  a_r8_reader_takes_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_frame_start && !frame_done |=> rd_idx == $past(done_idx));

  a_r8_rd_not_wr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx != wr_idx);

  a_r9_single_region: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !triple_en && !$past(triple_en) && !$past(triple_en, 2) |->
      int'(wr_addr) < BUF_WORDS);
endmodule

bind fbuf_addr_gen fbuf_addr_gen_chk #(
  .MAX_H(MAX_H), .LINE_WORDS(LINE_WORDS), .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .triple_en(triple_en),
  .rd_frame_start(rd_frame_start), .frame_done(frame_done),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_idx(wr_idx), .rd_idx(rd_idx), .done_idx(done_idx)
);

// File: tb/fbuf_addr_gen_test.sv
module fbuf_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 12;
  localparam int MAXH = 4;
  localparam int LW   = 3;
  localparam int BW   = 32;
  localparam int AW   = 7;

  logic clk = 1'b0, rst_n = 1'b0, triple_en = 1'b1;
  logic wr_pix_valid = 1'b0, wr_line_start = 1'b0, wr_frame_start = 1'b0;
  logic [23:0] wr_pix = '0;
  logic rd_frame_start = 1'b0, rd_line_start = 1'b0, rd_word_adv = 1'b0;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [127:0] wr_data;
  logic [1:0] rd_buf;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbuf_addr_gen #(.MAX_W(MAXW), .MAX_H(MAXH), .LINE_WORDS(LW),
                  .BUF_WORDS(BW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .triple_en(triple_en),
    .wr_pix_valid(wr_pix_valid), .wr_pix(wr_pix),
    .wr_line_start(wr_line_start), .wr_frame_start(wr_frame_start),
    .rd_frame_start(rd_frame_start), .rd_line_start(rd_line_start),
    .rd_word_adv(rd_word_adv), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_buf(rd_buf));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, expv);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_act, m_line, m_col, m_wmax, m_wi, m_rl, m_rw;
  int m_wbuf, m_rbuf, m_done;
  logic [23:0] pq[$];
  int mq_addr[$];
  int mq_data[$];
  bit exp_en;
  int exp_addr;
  logic [127:0] exp_data;
  string exp_tag, addr_tag;
  bit started = 0;

  function automatic logic [127:0] pack_pending();
    logic [127:0] d = '0;
    foreach (pq[i]) d[i*24 +: 24] = pq[i];
    return d;
  endfunction

  function automatic int pick_free(int a, int b);
    for (int i = 0; i < 3; i++) if (i != a && i != b) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    int eb, old_rd;
    started = 1;
    if (!rst_n) begin
      m_act = 0; m_line = 0; m_col = 0; m_wmax = 0; m_wi = 0; m_rl = 0; m_rw = 0;
      m_wbuf = 0; m_rbuf = 2; m_done = 2;
      pq.delete(); mq_addr.delete(); mq_data.delete();
      exp_en = 0; exp_tag = "R1"; addr_tag = "R1";
    end else begin
      eb = triple_en ? m_wbuf : 0;
      exp_en = 0; exp_tag = "R11"; addr_tag = "R3";
      if (mq_addr.size() > 0) begin
        exp_en = 1; exp_addr = mq_addr.pop_front();
        exp_data = 128'(mq_data.pop_front()); exp_tag = "R6"; addr_tag = "R6";
      end
      if (wr_frame_start) begin
        if (m_act != 0) begin
          if (pq.size() > 0) begin
            exp_en = 1; exp_addr = eb*BW + m_line*LW + m_wi;
            exp_data = pack_pending(); exp_tag = "R4"; addr_tag = "R4";
          end
          mq_addr.push_back(eb*BW + BW - 2);
          mq_data.push_back(m_col > m_wmax ? m_col : m_wmax);
          mq_addr.push_back(eb*BW + BW - 1);
          mq_data.push_back(m_line < MAXH ? m_line + 1 : MAXH);
          old_rd = m_rbuf;
          m_done = m_wbuf;
          if (rd_frame_start) begin
            m_rbuf = m_done; m_wbuf = old_rd;
          end else m_wbuf = pick_free(m_rbuf, m_done);
        end else if (rd_frame_start) m_rbuf = m_done;
        m_act = 1; m_line = 0; m_col = 0; m_wmax = 0; m_wi = 0; pq.delete();
      end else begin
        if (rd_frame_start) m_rbuf = m_done;
        if (wr_line_start) begin
          if (m_act != 0) begin
            if (pq.size() > 0) begin
              exp_en = 1; exp_addr = eb*BW + m_line*LW + m_wi;
              exp_data = pack_pending(); exp_tag = "R4"; addr_tag = "R4";
            end
            if (m_col > m_wmax) m_wmax = m_col;
            if (m_line < MAXH) m_line++;
            m_col = 0; m_wi = 0; pq.delete();
          end
        end else if (wr_pix_valid) begin
          if (m_act != 0 && m_line < MAXH && m_col < MAXW) begin
            pq.push_back(wr_pix); m_col++;
            if (pq.size() == 5) begin
              exp_en = 1; exp_addr = eb*BW + m_line*LW + m_wi;
              exp_data = pack_pending(); exp_tag = "R2"; addr_tag = "R3";
              m_wi++; pq.delete();
            end
          end else if (m_act != 0) exp_tag = "R5";
        end
      end
      if (rd_frame_start) begin m_rl = 0; m_rw = 0; end
      else if (rd_line_start) begin if (m_rl < MAXH - 1) m_rl++; m_rw = 0; end
      else if (rd_word_adv) begin if (m_rw < LW - 1) m_rw++; end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int rb;
    if (started) begin
      rb = triple_en ? m_rbuf : 0;
      chk(rd_buf == 2'(rb), triple_en ? "R8" : "R9", 128'(rd_buf), 128'(rb));
      chk(int'(rd_addr) == rb*BW + m_rl*LW + m_rw, "R10", 128'(rd_addr),
          128'(rb*BW + m_rl*LW + m_rw));
      chk(wr_en == exp_en, exp_tag, 128'(wr_en), 128'(exp_en));
      if (exp_en && wr_en) begin
        chk(int'(wr_addr) == exp_addr, addr_tag, 128'(wr_addr), 128'(exp_addr));
        chk(int'(wr_addr) / BW == exp_addr / BW, triple_en ? "R7" : "R9",
            128'(int'(wr_addr) / BW), 128'(exp_addr / BW));
        chk(wr_data == exp_data, exp_tag, wr_data, exp_data);
      end
    end
  end

  // ---------------- stimulus ----------------
  int pix_seed = 0;

  task automatic cyc(input bit fs, input bit ls, input bit pv,
                     input bit rfs, input bit rls, input bit radv);
    @(negedge clk); #1;
    wr_frame_start = fs; wr_line_start = ls; wr_pix_valid = pv;
    pix_seed++;
    wr_pix = 24'(32'h00A50000 + pix_seed * 37);
    rd_frame_start = rfs; rd_line_start = rls; rd_word_adv = radv;
  endtask

  task automatic pixels(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic new_frame(input bit with_read);
    cyc(1, 0, 0, with_read, 0, 0);
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    // R1: directed reset-state checks
    chk(wr_en == 1'b0, "R1", 128'(wr_en), 0);
    chk(rd_buf == 2'd2, "R1", 128'(rd_buf), 2);
    chk(int'(rd_addr) == 2*BW, "R1", 128'(rd_addr), 128'(2*BW));
    pixels(3);                       // R11: before any frame start
    new_frame(0);
    pixels(14);                      // R5: last two dropped
    cyc(0, 1, 0, 0, 0, 0);
    pixels(7);
    cyc(0, 1, 1, 0, 0, 0);           // R11: pixel on line strobe, R4 flush
    pixels(3);
    cyc(0, 1, 0, 0, 0, 0);
    pixels(5);
    cyc(0, 1, 0, 0, 0, 0);           // R5: line index saturates
    pixels(4);
    cyc(0, 1, 0, 0, 0, 0);
    new_frame(0);                    // R6 metadata, R7 rotation
    pixels(6);
    cyc(0, 0, 0, 1, 0, 0);           // R8
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    new_frame(1);                    // simultaneous read and write frame
    pixels(5);
    cyc(0, 1, 0, 0, 0, 0);
    pixels(2);
    cyc(0, 0, 0, 1, 0, 0);
    new_frame(0);
    pixels(3);
    idle(3);
    @(negedge clk); #1; triple_en = 1'b0;   // R9
    idle(2);
    new_frame(0);
    pixels(10);
    cyc(0, 1, 0, 0, 0, 0);
    pixels(4);
    cyc(0, 0, 0, 1, 0, 1);
    new_frame(0);
    idle(3);
    @(negedge clk); #1; triple_en = 1'b1;
    idle(2);
    new_frame(0);
    pixels(5);
    new_frame(1);
    pixels(12);
    idle(5);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule